// File: doc/BRIEF.md
# SMI Enable Register with Configuration Lock

This block keeps a 32-bit SMI enable register in an I/O-style register space and a 16-bit power-management configuration word in a byte-addressed configuration space. The two are tied together by a one-way lock. Firmware sets a lock bit in the configuration word. From then on, the global SMI enable bit in the other space is frozen. The lock bit also freezes itself, so only a reset can release it. All other bits of both registers stay writable.

Each space has a write port with valid, address and data, and a read port that returns data for the same clock. A state-restore port loads both registers at once and re-applies the lock. Nothing here raises an SMI. The block only holds the enable bits and the configuration word that the neighbouring logic decodes.

Top module: `smi_lock_unit`

## Requirements
- R1: A write to SMI offset 0 updates the register as new = (old & ~mask) | (data & mask). While unlocked, the mask is all ones. A write to any other SMI offset leaves the register unchanged.
- R2: After a synchronous active-high reset, the SMI register equals its reset parameter with the APM-control enable bit (bit 5) forced to 1 when SMM support is enabled (default 0x0000_0020). The configuration word reads 0x0000 and every bit is writable.
- R3: The configuration word sits at byte addresses 0xA0 (low byte) and 0xA1 (high byte). A configuration write of length 1 to 4 bytes puts data byte k at address addr+k. Only bytes that fall on 0xA0 or 0xA1 change the word.
- R4: Once the lock (bit 4 of the configuration word) is set, SMI writes leave bit 0 (global SMI enable) unchanged. All other SMI bits still take the written data.
- R5: Once locked, no configuration write can clear bit 4. The other 15 bits of the configuration word stay writable.
- R6: The APM-control enable (bit 5) stays writable, both to 0 and to 1, while locked.
- R7: An SMI write in the same clock as the configuration write that sets the lock is already masked: bit 0 keeps its old value.
- R8: A restore loads both registers directly and has priority over writes in the same clock. If the restored word has bit 4 set, the lock engages. A restore never clears an engaged lock, and bit 4 keeps reading 1.
- R9: An SMI read at offset 0 returns the register. A configuration read at 0xA0 returns the word. Reads at any other address return zero.
- R10: Reset releases the lock, so bit 0 of the SMI register becomes writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smiWrValid | input | 1 | SMI-space write strobe |
| smiWrAddr | input | 4 | SMI-space write offset |
| smiWrData | input | 32 | SMI-space write data |
| smiRdAddr | input | 4 | SMI-space read offset |
| smiRdData | output | 32 | SMI-space read data |
| cfgWrValid | input | 1 | Configuration write strobe |
| cfgWrAddr | input | 8 | Configuration write start byte address |
| cfgWrLen | input | 3 | Configuration write length in bytes (1 to 4) |
| cfgWrData | input | 32 | Configuration write data; byte k goes to address addr+k |
| cfgRdAddr | input | 8 | Configuration read address |
| cfgRdData | output | 16 | Configuration read data |
| restoreValid | input | 1 | Load both registers from the restore inputs |
| restoreSmi | input | 32 | Restored SMI register value |
| restoreCfg | input | 16 | Restored configuration word |

## Verification
The bench sets the lock with a write that also changes other bytes. It then checks that bit 0 holds in both directions while bit 5 and the other bits still follow the data. A design that applied the mask to the whole register, or locked the APM-control bit as well, would freeze those bits. Misaligned and partly overlapping configuration writes check the byte lane mapping; a design that ignored the start address would corrupt the word or miss the lock. A write that locks and masks in the same clock catches a design that uses the stale mask. Restores that try to clear the lock, or that collide with a write, catch a design that lets the restore unlock or that orders the two wrongly.

// File: rtl/smi_lock_pkg.sv
package smi_lock_pkg;
  // Strobes passed from the control half to the datapath half
  typedef struct packed {
    logic smiWe;        // SMI offset-0 write accepted this cycle
    logic restoreLd;    // load both registers from restore inputs
    logic lockEff;      // lock as seen by the SMI mask (includes this cycle's set)
    logic cfgLockHold;  // lock already held before this cycle (config self-mask)
  } lockStrobes_t;
endpackage

// File: rtl/smi_lock_ctrl.sv
module smi_lock_ctrl
  import smi_lock_pkg::*;
#(
  parameter int SMI_ADDR_W = 4,
  parameter int CFG_ADDR_W = 8,
  parameter int CFG_LEN_W  = 3,
  parameter int CFG_DW     = 32,
  parameter int CFG_W      = 16,
  parameter int CFG_OFFSET = 'hA0,
  parameter int CFG_SPAN   = 8,
  parameter int LOCK_BIT   = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               smiWrValid,
  input  logic [SMI_ADDR_W-1:0]              smiWrAddr,
  input  logic                               cfgWrValid,
  input  logic [CFG_ADDR_W-1:0]              cfgWrAddr,
  input  logic [CFG_LEN_W-1:0]               cfgWrLen,
  input  logic [CFG_DW-1:0]                  cfgWrData,
  input  logic                               restoreValid,
  input  logic [CFG_W-1:0]                   restoreCfg,
  input  logic                               cfgLockBitQ,
  output lockStrobes_t                       strobes,
  output logic [CFG_W/8-1:0]                 cfgByteWe,
  output logic [(CFG_W/8)*$clog2(CFG_DW/8)-1:0] cfgByteSel,
  output logic                               lockQ
);
  localparam int CFG_BYTES = CFG_W / 8;
  localparam int CFG_LANES = CFG_DW / 8;
  localparam int SEL_W     = $clog2(CFG_LANES);
  localparam int LOCK_BYTE = LOCK_BIT / 8;
  localparam int LOCK_POS  = LOCK_BIT % 8;

  // Per-byte decode of which data lane lands on each byte of the word
  for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byteDec
    int relIdx;
    always_comb begin
      relIdx = CFG_OFFSET + b - int'(cfgWrAddr);
      cfgByteWe[b] = cfgWrValid && !restoreValid && (relIdx >= 0)
                     && (relIdx < int'(cfgWrLen)) && (relIdx < CFG_LANES);
      cfgByteSel[b*SEL_W +: SEL_W] = relIdx[SEL_W-1:0];
    end
  end

  logic             overlap;
  logic             newLockBit;
  logic [SEL_W-1:0] lockSel;
  logic [7:0]       lockLane;
  logic             lockNext;

  always_comb begin
    overlap = cfgWrValid && !restoreValid && (int'(cfgWrLen) > 0)
              && (int'(cfgWrAddr) < CFG_OFFSET + CFG_SPAN)
              && (int'(cfgWrAddr) + int'(cfgWrLen) > CFG_OFFSET);
    lockSel  = cfgByteSel[LOCK_BYTE*SEL_W +: SEL_W];
    lockLane = cfgWrData[8*int'(lockSel) +: 8];
    newLockBit = cfgByteWe[LOCK_BYTE] ? lockLane[LOCK_POS] : cfgLockBitQ;
    lockNext = lockQ | (overlap & newLockBit)
               | (restoreValid & restoreCfg[LOCK_BIT]);
  end

  always_comb begin
    strobes.smiWe       = smiWrValid && (smiWrAddr == '0) && !restoreValid;
    strobes.restoreLd   = restoreValid;
    strobes.lockEff     = lockNext;
    strobes.cfgLockHold = lockQ;
  end

  always_ff @(posedge clk) begin
    if (rst) lockQ <= 1'b0;
    else     lockQ <= lockNext;
  end
endmodule

// File: rtl/smi_lock_datapath.sv
module smi_lock_datapath
  import smi_lock_pkg::*;
#(
  parameter int SMI_W       = 32,
  parameter int CFG_W       = 16,
  parameter int CFG_DW      = 32,
  parameter int GBL_BIT     = 0,
  parameter int APMC_BIT    = 5,
  parameter int LOCK_BIT    = 4,
  parameter logic [31:0] SMI_RST = 32'h0,
  parameter logic [15:0] CFG_RST = 16'h0,
  parameter bit SMM_SUPPORT = 1'b1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  lockStrobes_t                          strobes,
  input  logic [CFG_W/8-1:0]                    cfgByteWe,
  input  logic [(CFG_W/8)*$clog2(CFG_DW/8)-1:0] cfgByteSel,
  input  logic [SMI_W-1:0]                      smiWrData,
  input  logic [CFG_DW-1:0]                     cfgWrData,
  input  logic [SMI_W-1:0]                      restoreSmi,
  input  logic [CFG_W-1:0]                      restoreCfg,
  output logic [SMI_W-1:0]                      smiQ,
  output logic [CFG_W-1:0]                      cfgQ
);
  localparam int CFG_BYTES = CFG_W / 8;
  localparam int SEL_W     = $clog2(CFG_DW / 8);
  localparam int LOCK_BYTE = LOCK_BIT / 8;
  localparam int LOCK_POS  = LOCK_BIT % 8;
  localparam logic [SMI_W-1:0] GBL_ONE  = SMI_W'(1) << GBL_BIT;
  localparam logic [SMI_W-1:0] APMC_ONE = SMI_W'(1) << APMC_BIT;
  localparam logic [CFG_W-1:0] LOCK_ONE = CFG_W'(1) << LOCK_BIT;
  localparam logic [SMI_W-1:0] SMI_RST_EFF =
    SMM_SUPPORT ? (SMI_W'(SMI_RST) | APMC_ONE) : SMI_W'(SMI_RST);

  logic [SMI_W-1:0] smiMask;
  logic [SMI_W-1:0] smiNext;
  logic [CFG_W-1:0] cfgWritten;
  logic [CFG_W-1:0] cfgNext;

  always_comb begin
    smiMask = strobes.lockEff ? ~GBL_ONE : '1;
    if (strobes.restoreLd)  smiNext = restoreSmi;
    else if (strobes.smiWe) smiNext = (smiQ & ~smiMask) | (smiWrData & smiMask);
    else                    smiNext = smiQ;
  end

  // One lane per byte of the configuration word
  for (genvar b = 0; b < CFG_BYTES; b++) begin : g_cfgLane
    localparam logic [7:0] LOCK_IN_LANE = (b == LOCK_BYTE) ? 8'(1 << LOCK_POS) : 8'h00;
    logic [SEL_W-1:0] sel;
    logic [7:0]       laneMask;
    logic [7:0]       laneData;
    logic [7:0]       oldByte;
    always_comb begin
      sel      = cfgByteSel[b*SEL_W +: SEL_W];
      laneMask = strobes.cfgLockHold ? ~LOCK_IN_LANE : 8'hFF;
      laneData = cfgWrData[8*int'(sel) +: 8];
      oldByte  = cfgQ[8*b +: 8];
      cfgWritten[8*b +: 8] = cfgByteWe[b] ? ((oldByte & ~laneMask) | (laneData & laneMask))
                                          : oldByte;
    end
  end

  always_comb begin
    if (strobes.restoreLd)
      cfgNext = restoreCfg | (strobes.cfgLockHold ? LOCK_ONE : '0);
    else
      cfgNext = cfgWritten;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smiQ <= SMI_RST_EFF;
      cfgQ <= CFG_W'(CFG_RST);
    end else begin
      smiQ <= smiNext;
      cfgQ <= cfgNext;
    end
  end
endmodule

// File: rtl/smi_lock_unit.sv
module smi_lock_unit
  import smi_lock_pkg::*;
#(
  parameter int SMI_W       = 32,
  parameter int SMI_ADDR_W  = 4,
  parameter int CFG_W       = 16,
  parameter int CFG_ADDR_W  = 8,
  parameter int CFG_LEN_W   = 3,
  parameter int CFG_DW      = 32,
  parameter int CFG_OFFSET  = 'hA0,
  parameter int CFG_SPAN    = 8,
  parameter int GBL_BIT     = 0,
  parameter int APMC_BIT    = 5,
  parameter int LOCK_BIT    = 4,
  parameter logic [31:0] SMI_RST = 32'h0,
  parameter logic [15:0] CFG_RST = 16'h0,
  parameter bit SMM_SUPPORT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smiWrValid,
  input  logic [SMI_ADDR_W-1:0] smiWrAddr,
  input  logic [SMI_W-1:0]      smiWrData,
  input  logic [SMI_ADDR_W-1:0] smiRdAddr,
  output logic [SMI_W-1:0]      smiRdData,
  input  logic                  cfgWrValid,
  input  logic [CFG_ADDR_W-1:0] cfgWrAddr,
  input  logic [CFG_LEN_W-1:0]  cfgWrLen,
  input  logic [CFG_DW-1:0]     cfgWrData,
  input  logic [CFG_ADDR_W-1:0] cfgRdAddr,
  output logic [CFG_W-1:0]      cfgRdData,
  input  logic                  restoreValid,
  input  logic [SMI_W-1:0]      restoreSmi,
  input  logic [CFG_W-1:0]      restoreCfg
);
  localparam int CFG_BYTES = CFG_W / 8;
  localparam int SEL_W     = $clog2(CFG_DW / 8);

  lockStrobes_t               strobes;
  logic [CFG_BYTES-1:0]       cfgByteWe;
  logic [CFG_BYTES*SEL_W-1:0] cfgByteSel;
  logic                       lockQ;
  logic [SMI_W-1:0]           smiQ;
  logic [CFG_W-1:0]           cfgQ;

  smi_lock_ctrl #(
    .SMI_ADDR_W(SMI_ADDR_W), .CFG_ADDR_W(CFG_ADDR_W), .CFG_LEN_W(CFG_LEN_W),
    .CFG_DW(CFG_DW), .CFG_W(CFG_W), .CFG_OFFSET(CFG_OFFSET),
    .CFG_SPAN(CFG_SPAN), .LOCK_BIT(LOCK_BIT)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .smiWrValid(smiWrValid), .smiWrAddr(smiWrAddr),
    .cfgWrValid(cfgWrValid), .cfgWrAddr(cfgWrAddr), .cfgWrLen(cfgWrLen),
    .cfgWrData(cfgWrData),
    .restoreValid(restoreValid), .restoreCfg(restoreCfg),
    .cfgLockBitQ(cfgQ[LOCK_BIT]),
    .strobes(strobes), .cfgByteWe(cfgByteWe), .cfgByteSel(cfgByteSel),
    .lockQ(lockQ)
  );

  smi_lock_datapath #(
    .SMI_W(SMI_W), .CFG_W(CFG_W), .CFG_DW(CFG_DW), .GBL_BIT(GBL_BIT),
    .APMC_BIT(APMC_BIT), .LOCK_BIT(LOCK_BIT), .SMI_RST(SMI_RST),
    .CFG_RST(CFG_RST), .SMM_SUPPORT(SMM_SUPPORT)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .cfgByteWe(cfgByteWe), .cfgByteSel(cfgByteSel),
    .smiWrData(smiWrData), .cfgWrData(cfgWrData),
    .restoreSmi(restoreSmi), .restoreCfg(restoreCfg),
    .smiQ(smiQ), .cfgQ(cfgQ)
  );

  always_comb begin
    smiRdData = (smiRdAddr == '0) ? smiQ : '0;
    cfgRdData = (cfgRdAddr == CFG_ADDR_W'(CFG_OFFSET)) ? cfgQ : '0;
  end
endmodule

// File: rtl/smi_lock_chk.sv
module smi_lock_chk #(
  parameter int SMI_W       = 32,
  parameter int SMI_ADDR_W  = 4,
  parameter int CFG_W       = 16,
  parameter int GBL_BIT     = 0,
  parameter int APMC_BIT    = 5,
  parameter int LOCK_BIT    = 4,
  parameter logic [31:0] SMI_RST = 32'h0,
  parameter bit SMM_SUPPORT = 1'b1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  smiWrValid,
  input logic [SMI_ADDR_W-1:0] smiWrAddr,
  input logic [SMI_W-1:0]      smiWrData,
  input logic                  restoreValid,
  input logic [SMI_W-1:0]      smiVal,
  input logic [CFG_W-1:0]      cfgVal,
  input logic                  lockState
);
  localparam logic [SMI_W-1:0] EXP_RST =
    SMM_SUPPORT ? (SMI_W'(SMI_RST) | (SMI_W'(1) << APMC_BIT)) : SMI_W'(SMI_RST);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (smiVal == EXP_RST) && !lockState); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !smiWrValid && !restoreValid |=> $stable(smiVal)); // R1

  AST_GBL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    lockState && !restoreValid |=> smiVal[GBL_BIT] == $past(smiVal[GBL_BIT])); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lockState |=> lockState && cfgVal[LOCK_BIT]); // R5

  AST_APMC_WRITABLE: assert property (@(posedge clk) disable iff (rst)
    smiWrValid && (smiWrAddr == '0) && !restoreValid
      |=> smiVal[APMC_BIT] == $past(smiWrData[APMC_BIT])); // R6
endmodule

bind smi_lock_unit smi_lock_chk #(
  .SMI_W(SMI_W), .SMI_ADDR_W(SMI_ADDR_W), .CFG_W(CFG_W), .GBL_BIT(GBL_BIT),
  .APMC_BIT(APMC_BIT), .LOCK_BIT(LOCK_BIT), .SMI_RST(SMI_RST),
  .SMM_SUPPORT(SMM_SUPPORT)
) u_chk (
  .clk(clk), .rst(rst), .smiWrValid(smiWrValid), .smiWrAddr(smiWrAddr),
  .smiWrData(smiWrData), .restoreValid(restoreValid),
  .smiVal(smiQ), .cfgVal(cfgQ), .lockState(lockQ)
);

// File: tb/smi_lock_unit_bench.sv
module smi_lock_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smiWrValid = 1'b0;
  logic [3:0]  smiWrAddr = '0;
  logic [31:0] smiWrData = '0;
  logic [3:0]  smiRdAddr = '0;
  logic [31:0] smiRdData;
  logic        cfgWrValid = 1'b0;
  logic [7:0]  cfgWrAddr = '0;
  logic [2:0]  cfgWrLen = '0;
  logic [31:0] cfgWrData = '0;
  logic [7:0]  cfgRdAddr = 8'hA0;
  logic [15:0] cfgRdData;
  logic        restoreValid = 1'b0;
  logic [31:0] restoreSmi = '0;
  logic [15:0] restoreCfg = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  smi_lock_unit u_smi_lock_unit (
    .clk(clk), .rst(rst),
    .smiWrValid(smiWrValid), .smiWrAddr(smiWrAddr), .smiWrData(smiWrData),
    .smiRdAddr(smiRdAddr), .smiRdData(smiRdData),
    .cfgWrValid(cfgWrValid), .cfgWrAddr(cfgWrAddr), .cfgWrLen(cfgWrLen),
    .cfgWrData(cfgWrData), .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData),
    .restoreValid(restoreValid), .restoreSmi(restoreSmi), .restoreCfg(restoreCfg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic readSmi(input logic [3:0] a, output logic [31:0] v);
    smiRdAddr = a; #1; v = smiRdData;
  endtask

  task automatic readCfg(input logic [7:0] a, output logic [15:0] v);
    cfgRdAddr = a; #1; v = cfgRdData;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic smiWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); smiWrValid = 1'b1; smiWrAddr = a; smiWrData = d;
    @(negedge clk); smiWrValid = 1'b0;
  endtask

  task automatic cfgWr(input logic [7:0] a, input logic [2:0] l, input logic [31:0] d);
    @(negedge clk); cfgWrValid = 1'b1; cfgWrAddr = a; cfgWrLen = l; cfgWrData = d;
    @(negedge clk); cfgWrValid = 1'b0;
  endtask

  task automatic tReset();
    logic [31:0] s; logic [15:0] c;
    doReset();
    readSmi(4'h0, s); check("R2 smi reset", s, 32'h0000_0020);
    readCfg(8'hA0, c); check("R2 cfg reset", {16'h0, c}, 32'h0);
  endtask

  task automatic tSmiBasic();
    logic [31:0] s;
    smiWr(4'h0, 32'hFFFF_FFFF);
    readSmi(4'h0, s); check("R1 write all ones", s, 32'hFFFF_FFFF);
    smiWr(4'h0, 32'h0000_0000);
    readSmi(4'h0, s); check("R1 write zero", s, 32'h0);
    smiWr(4'h4, 32'h1234_5678);
    readSmi(4'h0, s); check("R1 other offset ignored", s, 32'h0);
    smiWr(4'h0, 32'hA5A5_0001);
    readSmi(4'h4, s); check("R9 smi read other offset", s, 32'h0);
    readSmi(4'h0, s); check("R9 smi read offset 0", s, 32'hA5A5_0001);
  endtask

  task automatic tCfgBytes();
    logic [15:0] c;
    cfgWr(8'hA1, 3'd1, 32'h0000_005A);
    readCfg(8'hA0, c); check("R3 high byte only", {16'h0, c}, 32'h5A00);
    cfgWr(8'h9F, 3'd4, 32'h1122_2344);
    readCfg(8'hA0, c); check("R3 misaligned 4-byte", {16'h0, c}, 32'h2223);
    cfgWr(8'hA2, 3'd2, 32'h0000_FFFF);
    readCfg(8'hA0, c); check("R3 non-overlapping bytes", {16'h0, c}, 32'h2223);
    readCfg(8'hA2, c); check("R9 cfg read other address", {16'h0, c}, 32'h0);
  endtask

  task automatic tLock();
    logic [31:0] s; logic [15:0] c;
    doReset();
    smiWr(4'h0, 32'h0000_0021);
    cfgWr(8'hA0, 3'd2, 32'h0000_0010);
    readCfg(8'hA0, c); check("R5 lock bit set", {16'h0, c}, 32'h0010);
    smiWr(4'h0, 32'h0000_0000);
    readSmi(4'h0, s); check("R4 gbl held at 1, R6 apmc cleared", s, 32'h0000_0001);
    smiWr(4'h0, 32'hFFFF_FFFE);
    readSmi(4'h0, s); check("R6 apmc set while locked", s, 32'hFFFF_FFFF);
    cfgWr(8'hA0, 3'd2, 32'h0000_ABCD);
    readCfg(8'hA0, c); check("R5 lock bit kept, others written", {16'h0, c}, 32'hABDD);
    doReset();
    smiWr(4'h0, 32'h0000_0000);
    readSmi(4'h0, s); check("R10 gbl writable after reset", s, 32'h0);
    readCfg(8'hA0, c); check("R10 cfg cleared by reset", {16'h0, c}, 32'h0);
  endtask

  task automatic tSameCycle();
    logic [31:0] s;
    doReset();
    smiWr(4'h0, 32'hFFFF_FFFF);
    @(negedge clk);
    smiWrValid = 1'b1; smiWrAddr = 4'h0; smiWrData = 32'h0;
    cfgWrValid = 1'b1; cfgWrAddr = 8'hA0; cfgWrLen = 3'd1; cfgWrData = 32'h10;
    @(negedge clk);
    smiWrValid = 1'b0; cfgWrValid = 1'b0;
    readSmi(4'h0, s); check("R7 same-cycle write masked", s, 32'h0000_0001);
  endtask

  task automatic tRestore();
    logic [31:0] s; logic [15:0] c;
    doReset();
    @(negedge clk);
    restoreValid = 1'b1; restoreSmi = 32'h0; restoreCfg = 16'h0010;
    @(negedge clk); restoreValid = 1'b0;
    smiWr(4'h0, 32'h0000_0001);
    readSmi(4'h0, s); check("R8 restore engages lock", s, 32'h0);
    @(negedge clk);
    restoreValid = 1'b1; restoreSmi = 32'h0000_0055; restoreCfg = 16'h0000;
    smiWrValid = 1'b1; smiWrAddr = 4'h0; smiWrData = 32'h0000_00AA;
    @(negedge clk); restoreValid = 1'b0; smiWrValid = 1'b0;
    readSmi(4'h0, s); check("R8 restore beats write", s, 32'h0000_0055);
    readCfg(8'hA0, c); check("R8 restore cannot clear lock", {16'h0, c}, 32'h0010);
    smiWr(4'h0, 32'h0000_0000);
    readSmi(4'h0, s); check("R8 still locked after restore", s, 32'h0000_0001);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tReset();
    tSmiBasic();
    tCfgBytes();
    tLock();
    tSameCycle();
    tRestore();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule